// File: doc/BRIEF.md
# Streaming 3x3 Laplacian Edge Filter

This block turns a raster-order stream of 8-bit grayscale pixels into a stream of edge-strength pixels of the same size. Each result is the Laplacian of the 3x3 neighbourhood centred on the matching source pixel. The result is clamped to the pixel range. Results on the image border are forced to zero.

The filter has two pipelined stages joined by a valid/ready stream. The column stage keeps the two previous image lines in line buffers. For every pixel from the third row on, it sends one word holding the three vertically stacked pixels at that horizontal position. The window stage keeps the two previous column words. With the incoming word they form the 3x3 window, and the stage computes the kernel on it. The window stage also inserts the zero border pixels, so each frame produces exactly one output per input pixel, in raster order.

Both edges of the block use valid/ready handshakes. Either side may stall at any time. A start-of-frame flag on an input pixel makes that pixel position (0,0) of a new frame. The image width and height are parameters, with a default of 512 by 512.

Top module: `edge_filter3x3`

## Requirements
- R1: After reset `in_ready` is 1 and `out_valid` is 0. A pixel is taken on each clock edge where `in_valid` and `in_ready` are both 1, and pixels are consumed in raster order: columns left to right, then rows top to bottom.
- R2: An output pixel at row r, column c, inside the border, equals 8 times source pixel (r,c) minus the sum of its eight neighbours (r±1, c±1).
- R3: The signed kernel sum is clamped before output: a negative sum gives 0 and a sum above 255 gives 255.
- R4: Output pixels in row 0, row H-1, column 0 and column W-1 are 0.
- R5: Each frame of W×H input pixels gives exactly W×H output pixels, in raster order, with no extra output.
- R6: No output pixel of a frame appears before the first pixel of the frame's third row (input number 2W+1) has been accepted.
- R7: Two output handshakes never occur on adjacent cycles. With input always valid and the sink always ready, the output handshakes inside a frame occur exactly 2 cycles apart.
- R8: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_pix` stay unchanged. Random stalls on the input and output sides lose and duplicate no pixel.
- R9: A pixel that arrives with `in_sof`=1 is taken as position (0,0) of a new frame. It discards the row and column position and the line-fill state of any partial frame before it. A partial frame shorter than two rows gives no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can accept an input pixel |
| in_pix | input | 8 | Input grayscale pixel |
| in_sof | input | 1 | Marks the input pixel as the first of a frame |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts the output pixel |
| out_pix | output | 8 | Edge-strength output pixel |

## Verification
Timing through the block is as follows:
- An accepted pixel from row two or later appears in the column register after one edge.
- The window stage takes that column only when its output register is empty. The result is visible on `out_pix` one edge after it takes the column.
- Border zeros are loaded into the same register whenever it is empty.

The bench drives inputs just after the rising edge and samples handshakes at the falling edge. A scoreboard pops one expected value for each output handshake, so results are checked by order and not at fixed cycle offsets. The bench records the cycle of each handshake to check the two-cycle spacing in unstalled frames. It also records the input count at the first output of each frame to check the line-fill rule.

// File: rtl/edge_pkg.sv
package edge_pkg;

    localparam int PIX_W        = 8;
    localparam int ACC_W        = PIX_W + 5;
    localparam int CENTRE_SHIFT = 3;
    localparam int NB_COUNT     = 8;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        pix_t top;
        pix_t mid;
        pix_t bot;
    } stack_t;

    typedef struct packed {
        logic   first;
        logic   last;
        logic   inner;
        stack_t px;
    } col_t;

    typedef enum logic [1:0] {
        WS_RUN,
        WS_LEAD,
        WS_TAIL
    } wstate_e;

    function automatic logic signed [ACC_W-1:0] widen(input pix_t p);
        return {{(ACC_W-PIX_W){1'b0}}, p};
    endfunction

    function automatic pix_t clamp_acc(input logic signed [ACC_W-1:0] a);
        if (a[ACC_W-1])
            return '0;
        else if (|a[ACC_W-2:PIX_W])
            return '1;
        else
            return a[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/edge_colgen.sv
module edge_colgen
    import edge_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    output logic in_ready,
    input  pix_t in_pix,
    input  logic in_sof,
    output logic col_valid,
    input  logic col_ready,
    output col_t col_o
);

    localparam int XW = $clog2(IMG_W);
    localparam int YW = $clog2(IMG_H);

    pix_t            lb_old [IMG_W];
    pix_t            lb_new [IMG_W];
    logic [XW-1:0]   x_q;
    logic [YW-1:0]   y_q;
    logic [XW-1:0]   ex;
    logic [YW-1:0]   ey;
    logic            accept;
    logic            row_end;
    logic            frame_end;
    logic            col_v_q;
    col_t            col_q;

    assign in_ready  = !col_v_q;
    assign accept    = in_valid && in_ready;
    assign ex        = in_sof ? '0 : x_q;
    assign ey        = in_sof ? '0 : y_q;
    assign row_end   = (ex == XW'(IMG_W - 1));
    assign frame_end = (ey == YW'(IMG_H - 1));
    assign col_valid = col_v_q;
    assign col_o     = col_q;

    always_ff @(posedge clk) begin
        if (accept) begin
            lb_old[ex] <= lb_new[ex];
            lb_new[ex] <= in_pix;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            x_q     <= '0;
            y_q     <= '0;
            col_v_q <= 1'b0;
            col_q   <= '0;
        end else begin
            if (col_v_q && col_ready)
                col_v_q <= 1'b0;
            if (accept) begin
                if (row_end) begin
                    x_q <= '0;
                    y_q <= frame_end ? '0 : ey + 1'b1;
                end else begin
                    x_q <= ex + 1'b1;
                    y_q <= ey;
                end
                if (ey >= YW'(2)) begin
                    col_v_q      <= 1'b1;
                    col_q.first  <= (ey == YW'(2)) && (ex == '0);
                    col_q.last   <= frame_end && row_end;
                    col_q.inner  <= (ex >= XW'(2));
                    col_q.px.top <= lb_old[ex];
                    col_q.px.mid <= lb_new[ex];
                    col_q.px.bot <= in_pix;
                end
            end
        end
    end

    AST_COL_HOLD: assert property (@(posedge clk) disable iff (rst)
        col_v_q && !col_ready |=> col_v_q && $stable(col_q)); // R8

    AST_ROW_FILL: assert property (@(posedge clk) disable iff (rst)
        accept && (ey < YW'(2)) && !(col_v_q && !col_ready) |=> !col_valid); // R6

    AST_IN_PACE: assert property (@(posedge clk) disable iff (rst)
        accept && (ey >= YW'(2)) |=> !in_ready); // R7

endmodule

// File: rtl/edge_kernel.sv
module edge_kernel
    import edge_pkg::*;
(
    input  stack_t left,
    input  stack_t centre,
    input  stack_t right,
    output pix_t   result
);

    pix_t                    nb [NB_COUNT];
    logic signed [ACC_W-1:0] acc;

    always_comb begin
        nb[0] = left.top;
        nb[1] = left.mid;
        nb[2] = left.bot;
        nb[3] = centre.top;
        nb[4] = centre.bot;
        nb[5] = right.top;
        nb[6] = right.mid;
        nb[7] = right.bot;
        acc = widen(centre.mid) <<< CENTRE_SHIFT;
        for (int i = 0; i < NB_COUNT; i++)
            acc = acc - widen(nb[i]);
    end

    assign result = clamp_acc(acc);

endmodule

// File: rtl/edge_window.sv
module edge_window
    import edge_pkg::*;
#(
    parameter int IMG_W = 512
) (
    input  logic clk,
    input  logic rst,
    input  logic col_valid,
    output logic col_ready,
    input  col_t col_i,
    output logic out_valid,
    input  logic out_ready,
    output pix_t out_pix
);

    localparam int CW = $clog2(IMG_W + 1);

    wstate_e        st_q;
    logic [CW-1:0]  cnt_q;
    logic           lead_done_q;
    stack_t         c1_q;
    stack_t         c2_q;
    pix_t           out_q;
    logic           out_v_q;
    logic           slot_free;
    logic           take;
    pix_t           lap;

    edge_kernel u_kernel (
        .left   (c2_q),
        .centre (c1_q),
        .right  (col_i.px),
        .result (lap)
    );

    assign slot_free = !out_v_q;
    assign col_ready = (st_q == WS_RUN) && slot_free && (!col_i.first || lead_done_q);
    assign take      = col_valid && col_ready;
    assign out_valid = out_v_q;
    assign out_pix   = out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q        <= WS_RUN;
            cnt_q       <= '0;
            lead_done_q <= 1'b0;
            c1_q        <= '0;
            c2_q        <= '0;
            out_q       <= '0;
            out_v_q     <= 1'b0;
        end else begin
            if (out_v_q && out_ready)
                out_v_q <= 1'b0;
            case (st_q)
                WS_RUN: begin
                    if (take) begin
                        c2_q    <= c1_q;
                        c1_q    <= col_i.px;
                        out_q   <= col_i.inner ? lap : '0;
                        out_v_q <= 1'b1;
                        if (col_i.first)
                            lead_done_q <= 1'b0;
                        if (col_i.last) begin
                            st_q  <= WS_TAIL;
                            cnt_q <= '0;
                        end
                    end else if (col_valid && slot_free && col_i.first && !lead_done_q) begin
                        st_q  <= WS_LEAD;
                        cnt_q <= '0;
                    end
                end
                WS_LEAD: begin
                    if (slot_free) begin
                        out_q   <= '0;
                        out_v_q <= 1'b1;
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == CW'(IMG_W - 2)) begin
                            st_q        <= WS_RUN;
                            lead_done_q <= 1'b1;
                        end
                    end
                end
                WS_TAIL: begin
                    if (slot_free) begin
                        out_q   <= '0;
                        out_v_q <= 1'b1;
                        cnt_q   <= cnt_q + 1'b1;
                        if (cnt_q == CW'(IMG_W))
                            st_q <= WS_RUN;
                    end
                end
                default: st_q <= WS_RUN;
            endcase
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        out_v_q && !out_ready |=> out_valid && $stable(out_pix)); // R8

    AST_OUT_PACE: assert property (@(posedge clk) disable iff (rst)
        out_valid && out_ready |=> !out_valid); // R7

    AST_BORDER_ZERO: assert property (@(posedge clk) disable iff (rst)
        take && !col_i.inner |=> out_valid && (out_pix == '0)); // R4

endmodule

// File: rtl/edge_filter3x3.sv
module edge_filter3x3
    import edge_pkg::*;
#(
    parameter int IMG_W = 512,
    parameter int IMG_H = 512
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [PIX_W-1:0] in_pix,
    input  logic             in_sof,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [PIX_W-1:0] out_pix
);

    logic col_valid;
    logic col_ready;
    col_t col_w;

    edge_colgen #(
        .IMG_W (IMG_W),
        .IMG_H (IMG_H)
    ) u_colgen (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .in_sof    (in_sof),
        .col_valid (col_valid),
        .col_ready (col_ready),
        .col_o     (col_w)
    );

    edge_window #(
        .IMG_W (IMG_W)
    ) u_window (
        .clk       (clk),
        .rst       (rst),
        .col_valid (col_valid),
        .col_ready (col_ready),
        .col_i     (col_w),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pix   (out_pix)
    );

endmodule

// File: tb/edge_filter3x3_bench.sv
module edge_filter3x3_bench;

    localparam int W     = 8;
    localparam int H     = 6;
    localparam int NPIX  = W * H;
    localparam int LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] in_pix = '0;
    logic       in_sof = 1'b0;
    logic       out_valid;
    logic       out_ready = 1'b1;
    logic [7:0] out_pix;

    int    img [H][W];
    int    exp_val [$];
    string exp_req [$];
    int    checks = 0;
    int    fails = 0;
    int    cyc = 0;
    int    out_idx = 0;
    int    last_hs = 0;
    int    acc_in_frame = 0;
    bit    bp_on = 0;
    bit    gaps_on = 0;
    bit    pace_on = 0;
    bit    done = 0;

    edge_filter3x3 #(.IMG_W(W), .IMG_H(H)) u_edge_filter3x3 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .in_pix    (in_pix),
        .in_sof    (in_sof),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_pix   (out_pix)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    always @(posedge clk) begin
        #1 out_ready = bp_on ? ($urandom_range(0, 2) != 0) : 1'b1;
    end

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    function automatic int ref_pix(int r, int c);
        int s;
        if (r == 0 || r == H-1 || c == 0 || c == W-1) return 0;
        s = 9 * img[r][c];
        for (int dr = -1; dr <= 1; dr++)
            for (int dc = -1; dc <= 1; dc++)
                s -= img[r+dr][c+dc];
        if (s < 0) return 0;
        if (s > 255) return 255;
        return s;
    endfunction

    // Scoreboard monitor: samples handshakes away from the rising edge
    always @(negedge clk) begin
        if (!rst && out_valid && out_ready) begin
            if (exp_val.size() == 0) begin
                check(0, "R5 extra output", out_pix, -1);
            end else begin
                int e;
                string rq;
                e  = exp_val.pop_front();
                rq = exp_req.pop_front();
                check(out_pix == e, rq, out_pix, e);
            end
            if (out_idx == 0)
                check(acc_in_frame >= 2*W+1, "R6 early output", acc_in_frame, 2*W+1);
            else if (pace_on)
                check(cyc - last_hs == 2, "R7 output spacing", cyc - last_hs, 2);
            if (out_idx != 0 || !pace_on)
                check(cyc - last_hs != 1 || out_idx == 0 && cyc == 0, "R7 back-to-back", cyc - last_hs, 2);
            last_hs = cyc;
            out_idx = (out_idx + 1) % NPIX;
        end
    end

    task automatic drive_pix(input int p, input bit sof);
        bit hs;
        if (gaps_on && $urandom_range(0, 3) == 0) begin
            in_valid = 1'b0;
            repeat ($urandom_range(1, 3)) @(posedge clk);
            #1;
        end
        in_valid = 1'b1;
        in_pix   = p[7:0];
        in_sof   = sof;
        do begin
            @(negedge clk);
            hs = in_ready;
            @(posedge clk);
            #1;
        end while (!hs);
        if (sof) acc_in_frame = 1;
        else     acc_in_frame++;
        in_valid = 1'b0;
        in_sof   = 1'b0;
    endtask

    task automatic send_frame();
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++) begin
                exp_val.push_back(ref_pix(r, c));
                if (r == 0 || r == H-1 || c == 0 || c == W-1)
                    exp_req.push_back("R4 border pixel");
                else
                    exp_req.push_back("R2/R3 kernel pixel");
            end
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                drive_pix(img[r][c], r == 0 && c == 0);
    endtask

    task automatic drain(input string tag);
        int n = 0;
        while (exp_val.size() != 0 && n < 5000) begin
            @(posedge clk);
            n++;
        end
        repeat (8) @(posedge clk);
        #1;
        check(exp_val.size() == 0, "R5 frame output count", NPIX - exp_val.size(), NPIX);
        check(out_idx == 0, {"R5 frame alignment ", tag}, out_idx, 0);
        exp_val.delete();
        exp_req.delete();
    endtask

    task automatic fill(input int v);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                img[r][c] = v;
    endtask

    initial begin
        while (!done && cyc < LIMIT) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, LIMIT);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(in_ready == 1'b1, "R1 ready after reset", in_ready, 1);
        check(out_valid == 1'b0, "R1 no output after reset", out_valid, 0);
        @(posedge clk);
        #1;

        // R2 flat field gives zero everywhere, R7 exact spacing
        pace_on = 1;
        fill(100);
        send_frame();
        drain("flat");

        // R3 bright dot: centre saturates high, neighbours clamp to 0
        fill(10);
        img[2][3] = 250;
        send_frame();
        drain("bright dot");

        // R3 dark dot: centre clamps to 0, neighbours give 200
        fill(200);
        img[3][4] = 0;
        send_frame();
        drain("dark dot");

        // R2 gradient pattern, R1 raster order
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                img[r][c] = (r * 37 + c * c * 11) % 256;
        send_frame();
        drain("gradient");

        // R8 random stalls on both sides
        pace_on = 0;
        bp_on   = 1;
        gaps_on = 1;
        for (int k = 0; k < 3; k++) begin
            for (int r = 0; r < H; r++)
                for (int c = 0; c < W; c++)
                    img[r][c] = $urandom_range(0, 255);
            send_frame();
            drain("stalled");
        end
        bp_on   = 0;
        gaps_on = 0;

        // R9 partial frame then a new start of frame
        drive_pix(255, 1'b1);
        for (int k = 0; k < W + 2; k++)
            drive_pix(255 - k * 7, 1'b0);
        repeat (20) @(posedge clk);
        #1;
        check(exp_val.size() == 0 && out_idx == 0, "R9 partial frame silent", out_idx, 0);
        for (int r = 0; r < H; r++)
            for (int c = 0; c < W; c++)
                img[r][c] = (r * 53 + c * 29 + 7) % 256;
        send_frame();
        drain("after restart");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule